// File: doc/BRIEF.md
# Cache Clean-and-Invalidate Index Walker

The walker is a hardware sequencer that empties a 4 Kbyte data cache in one pass. A single start pulse makes it visit every cache entry by index. The cache is split into 4 segments of 32 lines, and each line holds 32 bytes. At each entry the walker does a combined clean and flush. A line that is both valid and dirty is first written back to external memory over a request/acknowledge interface. The line is then invalidated. A line that is clean or invalid only loses its valid flag, and no request is made for it.

The address sent with each writeback has two parts. The segment number is in the two top address bits. The line offset is a multiple of 32 bytes in the low bits. The walker covers all lines of segment 0, then all lines of segment 1, and so on up to segment 3. The valid, dirty and line-data storage sits inside the block. A preload port is provided for test setup. It writes a line's flags and data while the walker is idle and reads back a line's flags one cycle later. The walker reports `busy` while it runs and gives a one-cycle `done` pulse when it finishes.

Top module: `cw_walker`

## Requirements
- R1: A synchronous active-high reset clears `busy`, `done`, `wb_req` and every line's valid and dirty flag.
- R2: A `start` pulse while idle makes `busy` high from the next clock edge.
- R3: Entries are visited in ascending order of index = segment*32 + line. All 32 lines of a segment are covered before the next segment. The writeback address is segment in bits [31:30], line in bits [9:5], and zero in all other bits.
- R4: A line that is valid and dirty raises `wb_req`, with its address and its 256-bit preloaded data on `wb_data`. The request, address and data stay stable until `wb_ack` is sampled high.
- R5: When a writeback is acknowledged, that line's valid and dirty flags are both cleared.
- R6: A line that is not both valid and dirty gets no request. Only its valid flag is cleared, and this takes exactly one cycle. A full walk is therefore busy for 128 + (writebacks × (ack wait + 1)) cycles.
- R7: `done` is high for exactly one cycle, after the last line of segment 3 is handled. `busy` falls at that same edge.
- R8: A `start` pulse while `busy` is high has no effect on the order, count or duration of the walk in progress.
- R9: `rd_valid`/`rd_dirty` show the flags of line `pre_idx` one cycle after `pre_idx` is presented. A `pre_we` write (index = `pre_idx`) stores `pre_valid`, `pre_dirty` and `pre_data` when the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Writeback address: segment and line |
| wb_data | output | 256 | Writeback line data |
| wb_ack | input | 1 | Writeback acknowledge |
| pre_we | input | 1 | Preload write enable |
| pre_idx | input | 7 | Preload/readback line index |
| pre_valid | input | 1 | Preload valid flag |
| pre_dirty | input | 1 | Preload dirty flag |
| pre_data | input | 256 | Preload line data |
| rd_valid | output | 1 | Readback valid flag of `pre_idx` |
| rd_dirty | output | 1 | Readback dirty flag of `pre_idx` |

## Verification
The assertions check several rules on every cycle. A pending request keeps its address steady until acknowledged. `done` lasts a single cycle and never overlaps `busy`. A walk begins only from an idle start. The segment counter moves only when the line counter wraps. An acknowledged line's dirty flag is gone on the next cycle. Other properties need the bench's scenarios against a reference model: the exact writeback order and data, the segment-boundary crossing, the flags left behind in every line, the walk duration under different acknowledge delays, and the effect of a start pulse in the middle of a walk.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VISIT = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_t;
endpackage

// File: rtl/cw_index_gen.sv
module cw_index_gen #(
  parameter int SEG_COUNT     = 4,
  parameter int LINES_PER_SEG = 32,
  parameter int LINE_BYTES    = 32,
  parameter int ADDR_W        = 32,
  localparam int SEG_W  = $clog2(SEG_COUNT),
  localparam int LINE_W = $clog2(LINES_PER_SEG),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = SEG_W + LINE_W,
  localparam int PAD_W  = ADDR_W - SEG_W - LINE_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [SEG_W-1:0]  seg_q;
  logic [LINE_W-1:0] line_q;
  logic              line_wrap;
  logic              seg_wrap;

  assign line_wrap = (line_q == LINE_W'(LINES_PER_SEG - 1));
  assign seg_wrap  = (seg_q == SEG_W'(SEG_COUNT - 1));
  assign last      = line_wrap && seg_wrap;
  assign idx       = {seg_q, line_q};
  assign addr      = {seg_q, {PAD_W{1'b0}}, line_q, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      seg_q  <= '0;
      line_q <= '0;
    end else if (step) begin
      if (line_wrap) begin
        line_q <= '0;
        seg_q  <= seg_wrap ? '0 : seg_q + 1'b1;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  // R3
  seg_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(seg_q) |-> (line_q == '0));
endmodule

// File: rtl/cw_line_store.sv
module cw_line_store #(
  parameter int LINES  = 128,
  parameter int DATA_W = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [IDX_W-1:0]  pre_idx,
  input  logic              pre_valid,
  input  logic              pre_dirty,
  input  logic [DATA_W-1:0] pre_data,
  output logic              rd_valid,
  output logic              rd_dirty,
  input  logic [IDX_W-1:0]  walk_idx,
  output logic              walk_valid,
  output logic              walk_dirty,
  output logic [DATA_W-1:0] walk_data,
  input  logic              clr_valid,
  input  logic              clr_dirty
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [DATA_W-1:0] mem [LINES];

  assign walk_valid = valid_q[walk_idx];
  assign walk_dirty = dirty_q[walk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      dirty_q  <= '0;
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else begin
      if (pre_we) begin
        valid_q[pre_idx] <= pre_valid;
        dirty_q[pre_idx] <= pre_dirty;
      end
      if (clr_valid) valid_q[walk_idx] <= 1'b0;
      if (clr_dirty) dirty_q[walk_idx] <= 1'b0;
      rd_valid <= valid_q[pre_idx];
      rd_dirty <= dirty_q[pre_idx];
    end
  end

  // Block-RAM style: no reset, synchronous write and read.
  always_ff @(posedge clk) begin
    if (pre_we) mem[pre_idx] <= pre_data;
    walk_data <= mem[walk_idx];
  end

  // R5
  ack_clears_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_dirty && !pre_we) |=> !dirty_q[$past(walk_idx)] && !valid_q[$past(walk_idx)]);
endmodule

// File: rtl/cw_walk_seq.sv
module cw_walk_seq
  import cw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              last,
  input  logic              cur_valid,
  input  logic              cur_dirty,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              wb_ack,
  output logic              restart,
  output logic              step,
  output logic              clr_valid,
  output logic              clr_dirty,
  output logic              busy,
  output logic              done,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr
);
  walk_st_t st_q;
  logic     need_wb;
  logic     acked;

  assign need_wb   = cur_valid && cur_dirty;
  assign acked     = (st_q == ST_WAIT) && wb_ack;
  assign restart   = (st_q == ST_IDLE) && start;
  assign step      = ((st_q == ST_VISIT) && !need_wb) || acked;
  assign clr_valid = step;
  assign clr_dirty = acked;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      wb_req  <= 1'b0;
      wb_addr <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q <= ST_VISIT;
            busy <= 1'b1;
          end
        end
        ST_VISIT: begin
          if (need_wb) begin
            wb_req  <= 1'b1;
            wb_addr <= cur_addr;
            st_q    <= ST_WAIT;
          end else if (last) begin
            st_q <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (wb_ack) begin
            wb_req <= 1'b0;
            if (last) begin
              st_q <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              st_q <= ST_VISIT;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> wb_req && $stable(wb_addr));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start) && !$past(busy));
endmodule

// File: rtl/cw_walker.sv
module cw_walker #(
  parameter int ADDR_W        = 32,
  parameter int SEG_COUNT     = 4,
  parameter int LINES_PER_SEG = 32,
  parameter int LINE_BYTES    = 32,
  localparam int LINES  = SEG_COUNT * LINES_PER_SEG,
  localparam int IDX_W  = $clog2(LINES),
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_ack,
  input  logic              pre_we,
  input  logic [IDX_W-1:0]  pre_idx,
  input  logic              pre_valid,
  input  logic              pre_dirty,
  input  logic [DATA_W-1:0] pre_data,
  output logic              rd_valid,
  output logic              rd_dirty
);
  logic              restart, step, clr_valid, clr_dirty, last;
  logic              cur_valid, cur_dirty;
  logic [IDX_W-1:0]  walk_idx;
  logic [ADDR_W-1:0] cur_addr;
  logic              pre_we_ok;

  assign pre_we_ok = pre_we && !busy;

  cw_index_gen #(
    .SEG_COUNT(SEG_COUNT), .LINES_PER_SEG(LINES_PER_SEG),
    .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)
  ) u_idx (
    .clk(clk), .rst(rst), .restart(restart), .step(step),
    .idx(walk_idx), .addr(cur_addr), .last(last)
  );

  cw_line_store #(.LINES(LINES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .pre_we(pre_we_ok), .pre_idx(pre_idx), .pre_valid(pre_valid),
    .pre_dirty(pre_dirty), .pre_data(pre_data),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .walk_idx(walk_idx), .walk_valid(cur_valid), .walk_dirty(cur_dirty),
    .walk_data(wb_data), .clr_valid(clr_valid), .clr_dirty(clr_dirty)
  );

  cw_walk_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .last(last),
    .cur_valid(cur_valid), .cur_dirty(cur_dirty), .cur_addr(cur_addr),
    .wb_ack(wb_ack), .restart(restart), .step(step),
    .clr_valid(clr_valid), .clr_dirty(clr_dirty),
    .busy(busy), .done(done), .wb_req(wb_req), .wb_addr(wb_addr)
  );

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> $stable(wb_data));
endmodule

// File: tb/cw_walker_bench.sv
module cw_walker_bench;
  logic         clk = 1'b0;
  logic         rst, start, wb_ack, pre_we, pre_valid, pre_dirty;
  logic [6:0]   pre_idx;
  logic [255:0] pre_data;
  logic         busy, done, wb_req, rd_valid, rd_dirty;
  logic [31:0]  wb_addr;
  logic [255:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit m_v [128];
  bit m_d [128];

  always #10 clk = ~clk;

  cw_walker u_cw_walker (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
    .pre_we(pre_we), .pre_idx(pre_idx), .pre_valid(pre_valid),
    .pre_dirty(pre_dirty), .pre_data(pre_data),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty)
  );

  // {index[6:0], valid, dirty}
  localparam logic [8:0] TAB [12] = '{
    {7'd0,   2'b11}, {7'd1,   2'b10}, {7'd2,  2'b01}, {7'd5,  2'b11},
    {7'd31,  2'b11}, {7'd32,  2'b11}, {7'd33, 2'b00}, {7'd63, 2'b10},
    {7'd64,  2'b11}, {7'd96,  2'b01}, {7'd100,2'b11}, {7'd127,2'b11}
  };

  function automatic logic [255:0] pat(int i);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = 32'hC0DE0000 ^ 32'(i * 256) ^ 32'(k);
    return r;
  endfunction

  function automatic logic [31:0] exp_addr(int i);
    logic [6:0] x;
    x = 7'(i);
    return {x[6:5], 20'b0, x[4:0], 5'b0};
  endfunction

  task automatic chk(bit ok, string rq, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic preload(int i, bit v, bit d);
    pre_we = 1'b1; pre_idx = 7'(i); pre_valid = v; pre_dirty = d; pre_data = pat(i);
    @(negedge clk);
    pre_we = 1'b0;
    m_v[i] = v; m_d[i] = d;
  endtask

  task automatic readback_all(string rq);
    for (int i = 0; i < 128; i++) begin
      pre_idx = 7'(i);
      @(negedge clk);
      chk(rd_valid == m_v[i] && rd_dirty == m_d[i], rq,
          {rd_valid, rd_dirty}, {m_v[i], m_d[i]});
    end
  endtask

  task automatic walk(int dly, bit poke);
    int nd = 0, ptr = 0, busy_n = 0, wbn = 0, wait_c = 0;
    bit got_done = 0;
    for (int i = 0; i < 128; i++) if (m_v[i] && m_d[i]) nd++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    for (int t = 0; t < 4000 && !got_done; t++) begin
      if (busy) busy_n++;
      start = (poke && t == 5);   // R8 start while busy
      if (done) begin
        got_done = 1;
        chk(busy == 1'b0, "R7 busy low with done", busy, 0);
      end else if (wb_req) begin
        if (wait_c == dly) begin
          int e = ptr;
          while (e < 128 && !(m_v[e] && m_d[e])) e++;
          chk(e < 128 && wb_addr == exp_addr(e), "R3 writeback order/address",
              wb_addr, exp_addr(e));
          chk(e < 128 && wb_data == pat(e), "R4 writeback data", wb_data, pat(e));
          ptr = e + 1; wbn++; wb_ack = 1'b1; wait_c = 0;
        end else begin
          wait_c++; wb_ack = 1'b0;
        end
      end else begin
        wb_ack = 1'b0;
      end
      if (!got_done) @(negedge clk);
    end
    start = 1'b0; wb_ack = 1'b0;
    chk(got_done, "R7 done seen", got_done, 1);
    chk(wbn == nd, "R4 writeback count", wbn, nd);
    chk(busy_n == 128 + nd * (dly + 1), "R6 R8 walk duration", busy_n, 128 + nd * (dly + 1));
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    for (int i = 0; i < 128; i++) begin
      if (m_v[i] && m_d[i]) m_d[i] = 0;
      m_v[i] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; wb_ack = 1'b0; pre_we = 1'b0;
    pre_idx = '0; pre_valid = 1'b0; pre_dirty = 1'b0; pre_data = '0;
    for (int i = 0; i < 128; i++) begin m_v[i] = 0; m_d[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && wb_req == 0, "R1 reset outputs",
        {busy, done, wb_req}, 0);

    // Table-driven preload, walk, and full flag readback
    for (int k = 0; k < 12; k++) preload(int'(TAB[k][8:2]), TAB[k][1], TAB[k][0]);
    pre_idx = 7'd5;
    @(negedge clk);
    chk(rd_valid && rd_dirty, "R9 readback after preload", {rd_valid, rd_dirty}, 2'b11);
    walk(0, 0);
    readback_all("R5 R6 flags after walk");

    // All lines dirty, slow ack, start poked mid-walk: full order check
    for (int i = 0; i < 128; i++) preload(i, 1, 1);
    walk(2, 1);
    readback_all("R5 all cleared");

    // Empty cache: one cycle per line, no requests
    walk(0, 0);

    // R1 reset clears preloaded flags
    preload(40, 1, 1);
    preload(90, 1, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_v[40] = 0; m_d[40] = 0; m_v[90] = 0; m_d[90] = 0;
    pre_idx = 7'd40;
    @(negedge clk);
    chk(!rd_valid && !rd_dirty, "R1 flags cleared by reset", {rd_valid, rd_dirty}, 0);
    pre_idx = 7'd90;
    @(negedge clk);
    chk(!rd_valid && !rd_dirty, "R1 flags cleared by reset", {rd_valid, rd_dirty}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule